// File: doc/BRIEF.md
# Next Fetch Address Steering with Counter Override

This block picks the address the front end fetches next. Every cycle it takes the current fetch address and the hit flag and target of a branch target cache kept outside the block. With no hit, the next address is the current one plus 4. With a hit, the cached target is taken at once, as a speculative guess. A direct-mapped table of 512 two-bit saturating counters also gives a taken or not-taken opinion for the same address. Its opinion is ready one cycle after the target-cache choice, and where the two differ the counter wins. So when the cache hit but the counter says not taken, the block raises a one-cycle redirect and steers fetch back to the fall-through address of that earlier fetch.

The execution unit trains the counters through an update port with the index address and the actual outcome of each resolved branch. Branches whose word addresses agree in the low index bits share one counter. The block does not try to keep them apart. The target cache and the branch execution logic sit outside this block.

Top module: `nfa_fetch_steer`

## Requirements
- R1: After reset every counter holds 01 (weakly not taken), and `redirect` is 0 in the first cycle after reset.
- R2: When `redirect` is 0 and `tc_hit` is 0, `next_addr` equals `fetch_addr + 4` in the same cycle.
- R3: When `redirect` is 0 and `tc_hit` is 1, `next_addr` equals `tc_target` in the same cycle.
- R4: A valid fetch that hits in the target cache while its counter holds 00 or 01 (not taken) makes `redirect` 1 in the next cycle, with `next_addr` equal to that fetch's address plus 4.
- R5: A valid fetch that hits while its counter holds 10 or 11 (taken) raises no redirect in the next cycle.
- R6: A valid fetch that misses raises no redirect in the next cycle, even when its counter predicts taken.
- R7: An update moves the indexed counter up by one on a taken outcome and down by one on a not-taken one, saturating at 11 and 00 with no wraparound.
- R8: The counter index is `addr[10:2]`. Addresses that differ only above bit 10 share one counter.
- R9: A lookup and an update to the same index in one cycle both take place, and the lookup uses the counter value from before the update.
- R10: A fetch presented while `redirect` is 1 is on the wrong path. It never causes a redirect, so `redirect` is never 1 in two cycles in a row.
- R11: A cycle with `fetch_valid` 0 causes no redirect in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_valid | input | 1 | The current fetch address is a real fetch |
| fetch_addr | input | 32 | Current fetch address |
| tc_hit | input | 1 | Target cache hit for the current fetch |
| tc_target | input | 32 | Target supplied by the target cache |
| upd_valid | input | 1 | Resolved branch outcome is present |
| upd_addr | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome: 1 taken, 0 not taken |
| next_addr | output | 32 | Next fetch address |
| redirect | output | 1 | Counter override of an earlier taken guess |

## Verification
The bench probes fetches with hit and miss against counters driven to each of the four states, so that a redirect appears only in the hit/not-taken pairing and never from a miss. It drives long runs of one outcome followed by the opposite one, which tells a saturating counter from a wrapping one. It also trains one address and probes an alias that differs only above the index. Last, it collides an update with a lookup in the same cycle, and it fetches during a redirect cycle to confirm that wrong-path fetch is squashed.

// File: rtl/nfa_pkg.sv
// Shared types and helpers for the next-fetch-address steering block.
// Assumes a 2-bit counter encoding where the top bit is the direction.
package nfa_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_INIT = 2'b01;
    localparam ctr_t CTR_MAX  = 2'b11;
    localparam ctr_t CTR_MIN  = 2'b00;

    // Direction of a counter: upper half of the range means taken.
    function automatic logic ctr_taken(input ctr_t c);
        return c[1];
    endfunction

    // Saturating step of a counter toward the observed outcome.
    function automatic ctr_t ctr_step(input ctr_t c, input logic taken);
        ctr_t n;
        n = c;
        if (taken && c != CTR_MAX)
            n = c + 2'b01;
        else if (!taken && c != CTR_MIN)
            n = c - 2'b01;
        return n;
    endfunction

endpackage

// File: rtl/nfa_ctr_table.sv
// Direct-mapped table of 2-bit saturating direction counters.
// One combinational read port and one write port. The read returns the
// stored value, so a same-cycle write to that index is not yet seen.
// Assumes the caller supplies ready-made indices.
module nfa_ctr_table
    import nfa_pkg::*;
#(
    parameter int ENTRIES = 512,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_t             rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);

    ctr_t cells [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cell
        ctr_t cell_q;

        // Hold one counter; reset to weakly not taken, step on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cell_q <= CTR_INIT;
            else if (wr_en && wr_idx == IDX_W'(i))
                cell_q <= ctr_step(cell_q, wr_taken);
        end

        assign cells[i] = cell_q;
    end

    // Read the addressed counter (value before any write this cycle).
    always_comb begin
        rd_ctr = cells[rd_idx];
    end

endmodule

// File: rtl/nfa_pred_stage.sv
// Second-cycle stage: keeps the hit flag, fall-through address and counter
// value of the previous fetch, and flags an override when the cache
// guessed taken but the counter says not taken.
// Assumes the caller clears cap_en for squashed fetches.
module nfa_pred_stage
    import nfa_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic              cap_hit,
    input  logic [ADDR_W-1:0] cap_seq,
    input  ctr_t              cap_ctr,
    output logic              corr,
    output logic [ADDR_W-1:0] corr_addr
);

    logic              v_q;
    logic              hit_q;
    logic [ADDR_W-1:0] seq_q;
    ctr_t              ctr_q;

    // Capture the current fetch's prediction inputs for the override check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q   <= 1'b0;
            hit_q <= 1'b0;
            seq_q <= '0;
            ctr_q <= CTR_INIT;
        end else begin
            v_q   <= cap_en;
            hit_q <= cap_hit;
            seq_q <= cap_seq;
            ctr_q <= cap_ctr;
        end
    end

    // Override when the counter disagrees with a taken cache guess.
    always_comb begin
        corr      = v_q && hit_q && !ctr_taken(ctr_q);
        corr_addr = seq_q;
    end

endmodule

// File: rtl/nfa_addr_mux.sv
// Next-fetch-address selector. Priority order: counter override first,
// then the cache target on a hit, then fall-through.
// Assumes all inputs are settled within the cycle.
module nfa_addr_mux #(
    parameter int ADDR_W = 32
) (
    input  logic              corr,
    input  logic [ADDR_W-1:0] corr_addr,
    input  logic              hit,
    input  logic [ADDR_W-1:0] target,
    input  logic [ADDR_W-1:0] seq_addr,
    output logic [ADDR_W-1:0] next_addr
);

    // Choose the next fetch address by priority.
    always_comb begin
        if (corr)
            next_addr = corr_addr;
        else if (hit)
            next_addr = target;
        else
            next_addr = seq_addr;
    end

endmodule

// File: rtl/nfa_fetch_steer.sv
// Top of the next-fetch-address steering block. Joins the counter table,
// the override stage and the address selector. Assumes 4-byte aligned
// fetches; the index comes from the bits just above the byte offset.
module nfa_fetch_steer
    import nfa_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int ENTRIES     = 512,
    parameter int INSTR_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              tc_hit,
    input  logic [ADDR_W-1:0] tc_target,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic              upd_taken,
    output logic [ADDR_W-1:0] next_addr,
    output logic              redirect
);

    localparam int IDX_W = $clog2(ENTRIES);
    localparam int OFS_W = $clog2(INSTR_BYTES);
    localparam int IDX_HI = IDX_W + OFS_W - 1;

    logic [IDX_W-1:0]  rd_idx;
    logic [IDX_W-1:0]  wr_idx;
    logic [ADDR_W-1:0] seq_addr;
    logic [ADDR_W-1:0] corr_addr;
    ctr_t              rd_ctr;
    logic              corr;
    logic              cap_en;
    logic              unused_upd_bits;

    // Derive table indices, fall-through address and stage capture enable.
    always_comb begin
        rd_idx   = fetch_addr[IDX_HI:OFS_W];
        wr_idx   = upd_addr[IDX_HI:OFS_W];
        seq_addr = fetch_addr + ADDR_W'(INSTR_BYTES);
        cap_en   = fetch_valid && !corr;
    end

    assign unused_upd_bits = ^{upd_addr[ADDR_W-1:IDX_HI+1], upd_addr[OFS_W-1:0]};

    nfa_ctr_table #(
        .ENTRIES (ENTRIES)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (rd_idx),
        .rd_ctr   (rd_ctr),
        .wr_en    (upd_valid),
        .wr_idx   (wr_idx),
        .wr_taken (upd_taken)
    );

    nfa_pred_stage #(
        .ADDR_W (ADDR_W)
    ) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (cap_en),
        .cap_hit   (tc_hit),
        .cap_seq   (seq_addr),
        .cap_ctr   (rd_ctr),
        .corr      (corr),
        .corr_addr (corr_addr)
    );

    nfa_addr_mux #(
        .ADDR_W (ADDR_W)
    ) u_mux (
        .corr      (corr),
        .corr_addr (corr_addr),
        .hit       (tc_hit),
        .target    (tc_target),
        .seq_addr  (seq_addr),
        .next_addr (next_addr)
    );

    assign redirect = corr;

endmodule

// File: rtl/nfa_fetch_steer_chk.sv
// Protocol checker for nfa_fetch_steer, attached with bind.
// Relates ports across cycles; assumes 4-byte instructions.
module nfa_fetch_steer_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_valid,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              tc_hit,
    input logic [ADDR_W-1:0] tc_target,
    input logic [ADDR_W-1:0] next_addr,
    input logic              redirect
);

    // R1: no redirect in the cycle after a reset cycle
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !redirect);

    // R2: fall-through on a miss without override
    a_r2_seq_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect && !tc_hit) |-> next_addr == fetch_addr + ADDR_W'(4));

    // R3: cached target on a hit without override
    a_r3_target_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect && tc_hit) |-> next_addr == tc_target);

    // R4: a redirect returns to the previous fetch's fall-through
    a_r4_redirect_addr: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> next_addr == $past(fetch_addr) + ADDR_W'(4));

    // R6: a miss never leads to a redirect
    a_r6_miss_no_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        (!tc_hit && !redirect) |=> !redirect);

    // R10: redirect lasts one cycle
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> !redirect);

    // R11: an idle cycle leads to no redirect
    a_r11_idle_no_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |=> !redirect);

endmodule

bind nfa_fetch_steer nfa_fetch_steer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_valid (fetch_valid),
    .fetch_addr  (fetch_addr),
    .tc_hit      (tc_hit),
    .tc_target   (tc_target),
    .next_addr   (next_addr),
    .redirect    (redirect)
);

// File: tb/nfa_fetch_steer_test.sv
// Directed bench for nfa_fetch_steer: one task per scenario.
module nfa_fetch_steer_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        tc_hit = 1'b0;
    logic [31:0] tc_target = '0;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_addr = '0;
    logic        upd_taken = 1'b0;
    logic [31:0] next_addr;
    logic        redirect;

    int checks = 0;
    int failures = 0;

    localparam logic [31:0] TGT = 32'h0000_8000;

    nfa_fetch_steer uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_valid (fetch_valid),
        .fetch_addr  (fetch_addr),
        .tc_hit      (tc_hit),
        .tc_target   (tc_target),
        .upd_valid   (upd_valid),
        .upd_addr    (upd_addr),
        .upd_taken   (upd_taken),
        .next_addr   (next_addr),
        .redirect    (redirect)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present one fetch, check same-cycle address and next-cycle redirect.
    task automatic probe(input logic [31:0] a, input logic hit, input logic exp_redir,
                         input string req);
        @(negedge clk);
        fetch_valid = 1'b1;
        fetch_addr  = a;
        tc_hit      = hit;
        tc_target   = TGT;
        #1;
        check({req, " same-cycle addr"}, next_addr, hit ? TGT : a + 32'd4);
        @(posedge clk);
        #1;
        check({req, " redirect"}, {31'b0, redirect}, {31'b0, exp_redir});
        if (exp_redir)
            check({req, " redirect addr"}, next_addr, a + 32'd4);
        @(negedge clk);
        fetch_valid = 1'b0;
        tc_hit      = 1'b0;
    endtask

    // Apply n outcome updates to one address.
    task automatic train(input logic [31:0] a, input logic taken, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            upd_valid = 1'b1;
            upd_addr  = a;
            upd_taken = taken;
            @(negedge clk);
            upd_valid = 1'b0;
        end
    endtask

    task automatic t_reset;
        @(posedge clk);
        #1;
        check("R1 redirect after reset", {31'b0, redirect}, 32'd0);
        probe(32'h0000_1000, 1'b1, 1'b1, "R1 R4 fresh counter not taken");
    endtask

    task automatic t_seq;
        probe(32'h0000_1040, 1'b0, 1'b0, "R2 miss falls through");
        train(32'h0000_1018, 1'b1, 2);
        probe(32'h0000_1018, 1'b0, 1'b0, "R6 taken counter but miss");
    endtask

    task automatic t_hit;
        train(32'h0000_1000, 1'b1, 2);
        probe(32'h0000_1000, 1'b1, 1'b0, "R3 R5 counter 11 keeps target");
    endtask

    task automatic t_sat_hi;
        train(32'h0000_1000, 1'b1, 5);
        train(32'h0000_1000, 1'b0, 1);
        probe(32'h0000_1000, 1'b1, 1'b0, "R7 saturate at 11 then 10");
        train(32'h0000_1000, 1'b0, 1);
        probe(32'h0000_1000, 1'b1, 1'b1, "R7 10 down to 01");
    endtask

    task automatic t_sat_lo;
        train(32'h0000_1004, 1'b0, 5);
        train(32'h0000_1004, 1'b1, 1);
        probe(32'h0000_1004, 1'b1, 1'b1, "R7 saturate at 00 then 01");
        train(32'h0000_1004, 1'b1, 1);
        probe(32'h0000_1004, 1'b1, 1'b0, "R7 01 up to 10");
    endtask

    task automatic t_alias;
        train(32'h0000_1008, 1'b1, 2);
        probe(32'h0000_1808, 1'b1, 1'b0, "R8 alias shares counter");
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        fetch_valid = 1'b1;
        fetch_addr  = 32'h0000_100C;
        tc_hit      = 1'b1;
        tc_target   = TGT;
        upd_valid   = 1'b1;
        upd_addr    = 32'h0000_100C;
        upd_taken   = 1'b1;
        @(posedge clk);
        #1;
        check("R9 lookup sees old 01", {31'b0, redirect}, 32'd1);
        @(negedge clk);
        fetch_valid = 1'b0;
        tc_hit      = 1'b0;
        upd_valid   = 1'b0;
        probe(32'h0000_100C, 1'b1, 1'b0, "R9 update applied to 10");
    endtask

    task automatic t_squash;
        @(negedge clk);
        fetch_valid = 1'b1;
        fetch_addr  = 32'h0000_1010;
        tc_hit      = 1'b1;
        tc_target   = TGT;
        @(posedge clk);
        #1;
        check("R10 first redirect", {31'b0, redirect}, 32'd1);
        @(negedge clk);
        fetch_addr = 32'h0000_1014;
        #1;
        check("R10 override beats hit", next_addr, 32'h0000_1014);
        @(posedge clk);
        #1;
        check("R10 wrong-path fetch squashed", {31'b0, redirect}, 32'd0);
        @(negedge clk);
        fetch_valid = 1'b0;
        tc_hit      = 1'b0;
    endtask

    task automatic t_idle;
        @(negedge clk);
        fetch_valid = 1'b0;
        fetch_addr  = 32'h0000_1010;
        tc_hit      = 1'b1;
        @(posedge clk);
        #1;
        check("R11 invalid fetch no redirect", {31'b0, redirect}, 32'd0);
        @(negedge clk);
        tc_hit = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_seq();
        t_hit();
        t_sat_hi();
        t_sat_lo();
        t_alias();
        t_same_cycle();
        t_squash();
        t_idle();
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule